// File: doc/BRIEF.md
# Long-Mode Interrupt Dispatch Sequencer

This block delivers one interrupt in 64-bit mode. A one-cycle start pulse latches the interrupt vector and the current architectural context: return RIP, RSP, RFLAGS, the CS and SS selectors and the current privilege level. The block then steps through a fixed series of memory accesses on a single 64-bit request/response port. It reads the 16-byte gate from the interrupt descriptor table and then the target code-segment descriptor from the global or local table. Next it probes the two ends of the new stack frame and finally stores a five-quadword frame.

Only once every check has passed does the block present the new RIP, CS, SS, RSP and RFLAGS, all together with a one-cycle done pulse. Two kinds of failure end the sequence early with done and no state change. A malformed gate or an error response raises `fault`. A request for a stack switch, either through the stack-table index or through a privilege change, raises `unsup`, since this block does not perform stack switching.

The table bases are live inputs and must be held stable while `busy` is high. Memory requests stay valid until they are accepted. Each read receives exactly one response, carrying data and an error flag. A write is complete when its request is accepted.

Top module: `lm_irq_dispatch`

## Requirements
- R1: After start, the first two reads go to `idt_base + vector*16` and `idt_base + vector*16 + 8`, in that order.
- R2: Gate bits 43:41 must be 3'b111 (type 0xE or 0xF) and bit 47 (present) must be 1. Otherwise the sequence ends after the first read with `done` and `fault`, no writes, and the new-state outputs unchanged.
- R3: The target selector is gate bits 31:16. The third read goes to `gdt_base + (sel & 0xF8)` when sel bit 2 is 0, and to `ldt_base + (sel & 0xF8)` when it is 1.
- R4: If gate bits 34:32 are nonzero, the sequence ends after the third read with `done` and `unsup`, with no writes and no state change.
- R5: If bits 46:45 of the code descriptor differ from `cur_cpl`, the sequence ends after the third read with `done` and `unsup`, with no writes and no state change.
- R6: The frame base is `(cur_rsp - 40) & ~0xF`. Reads at the base and at base+32 are made before any write. An error response on any read ends the sequence with `done` and `fault`, with no writes and no state change.
- R7: Five writes follow, in this order, to base+0, +8, +16, +24 and +32. They carry the return RIP, the zero-extended CS, the old RFLAGS, the old RSP and the zero-extended SS.
- R8: On success, `new_rip` = {high-gate bits 31:0, gate bits 63:48, gate bits 15:0}.
- R9: On success, `new_rflags` is the old RFLAGS with bits 8, 14 and 16 cleared and bit 9 set equal to gate bit 40.
- R10: On success, `new_cs` is the gate selector, `new_ss` is `cur_ss` and `new_rsp` is the frame base.
- R11: `done` is a one-cycle pulse. `fault` and `unsup` are high only together with `done`, and never both at once. The new-state outputs change only in a successful done cycle.
- R12: A request whose `mem_req_ready` is low stays valid with the same address and direction in the next cycle. Start is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin delivery (ignored while busy) |
| vector | input | 8 | Interrupt vector |
| cur_rip | input | 64 | Return instruction pointer |
| cur_rsp | input | 64 | Current stack pointer |
| cur_rflags | input | 64 | Current flags |
| cur_cs | input | 16 | Current code selector |
| cur_ss | input | 16 | Current stack selector |
| cur_cpl | input | 2 | Current privilege level |
| idt_base | input | 64 | Interrupt table base |
| gdt_base | input | 64 | Global table base |
| ldt_base | input | 64 | Local table base |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 64 | Request byte address |
| mem_req_wdata | output | 64 | Write data |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_rdata | input | 64 | Read response data |
| mem_rsp_err | input | 1 | Read response error |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | End-of-sequence pulse |
| fault | output | 1 | Gate or access fault (with done) |
| unsup | output | 1 | Stack switch requested (with done) |
| new_rip | output | 64 | Committed RIP |
| new_cs | output | 16 | Committed CS selector |
| new_ss | output | 16 | Committed SS selector |
| new_rsp | output | 64 | Committed RSP |
| new_rflags | output | 64 | Committed RFLAGS |

## Verification
The hardest case to reach is an access failure that appears only at the very end of validation. Here the gate and the code descriptor are both valid and the lowest probe has succeeded, but the probe at base+32 returns an error. The bench memory model injects an error on one chosen address, set to the top of a frame whose first four reads are clean. It then confirms from the read and write logs and from the held outputs that nothing was stored or committed. A second start issued mid-sequence with a different vector, against a memory that stalls acceptance in a fixed pattern, shows that the latched context alone decides the result.

// File: rtl/lm_irq_dispatch.sv
module lm_irq_dispatch #(
  parameter int AW = 64,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    vector,
  input  logic [DW-1:0] cur_rip,
  input  logic [DW-1:0] cur_rsp,
  input  logic [DW-1:0] cur_rflags,
  input  logic [15:0]   cur_cs,
  input  logic [15:0]   cur_ss,
  input  logic [1:0]    cur_cpl,
  input  logic [AW-1:0] idt_base,
  input  logic [AW-1:0] gdt_base,
  input  logic [AW-1:0] ldt_base,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_rdata,
  input  logic          mem_rsp_err,
  output logic          busy,
  output logic          done,
  output logic          fault,
  output logic          unsup,
  output logic [DW-1:0] new_rip,
  output logic [15:0]   new_cs,
  output logic [15:0]   new_ss,
  output logic [AW-1:0] new_rsp,
  output logic [DW-1:0] new_rflags
);

  localparam int FRAME_BYTES = 40;
  localparam int LAST_STEP   = 9;
  localparam int FIRST_WR    = 5;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP} st_t;

  st_t             st;
  logic [3:0]      step;
  logic [7:0]      l_vec;
  logic [DW-1:0]   l_rip, l_rsp, l_flg;
  logic [15:0]     l_cs, l_ss;
  logic [1:0]      l_cpl;
  logic [DW-1:0]   g_lo, g_hi;

  logic [15:0]     sel;
  logic [AW-1:0]   gate_a, cs_a, frame;
  logic [DW-1:0]   flg_out;
  logic            gate_ok, bad, stk_sw;

  assign sel    = g_lo[31:16];
  assign gate_a = idt_base + {{(AW-12){1'b0}}, l_vec, 4'h0};
  assign cs_a   = (sel[2] ? ldt_base : gdt_base) + {{(AW-16){1'b0}}, sel & 16'h00F8};
  assign frame  = (l_rsp - AW'(FRAME_BYTES)) & ~{{(AW-4){1'b0}}, 4'hF};

  assign gate_ok = (mem_rsp_rdata[43:41] == 3'b111) && mem_rsp_rdata[47];
  assign stk_sw  = (g_lo[34:32] != 3'd0) || (mem_rsp_rdata[46:45] != l_cpl);

  always_comb begin
    flg_out     = l_flg;
    flg_out[8]  = 1'b0;
    flg_out[14] = 1'b0;
    flg_out[16] = 1'b0;
    flg_out[9]  = g_lo[40];
  end

  always_comb begin
    bad = mem_rsp_err;
    if (step == 4'd0) bad = mem_rsp_err || !gate_ok;
  end

  assign busy          = (st != S_IDLE);
  assign mem_req_valid = (st == S_REQ);
  assign mem_req_write = (step >= 4'(FIRST_WR));

  always_comb begin
    mem_req_addr  = frame;
    mem_req_wdata = '0;
    case (step)
      4'd0: mem_req_addr = gate_a;
      4'd1: mem_req_addr = gate_a + AW'(8);
      4'd2: mem_req_addr = cs_a;
      4'd3: mem_req_addr = frame;
      4'd4: mem_req_addr = frame + AW'(32);
      4'd5: begin mem_req_addr = frame;           mem_req_wdata = l_rip; end
      4'd6: begin mem_req_addr = frame + AW'(8);  mem_req_wdata = {{(DW-16){1'b0}}, l_cs}; end
      4'd7: begin mem_req_addr = frame + AW'(16); mem_req_wdata = l_flg; end
      4'd8: begin mem_req_addr = frame + AW'(24); mem_req_wdata = l_rsp; end
      4'd9: begin mem_req_addr = frame + AW'(32); mem_req_wdata = {{(DW-16){1'b0}}, l_ss}; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; step <= '0;
      done <= 1'b0; fault <= 1'b0; unsup <= 1'b0;
      l_vec <= '0; l_rip <= '0; l_rsp <= '0; l_flg <= '0;
      l_cs <= '0; l_ss <= '0; l_cpl <= '0; g_lo <= '0; g_hi <= '0;
      new_rip <= '0; new_cs <= '0; new_ss <= '0; new_rsp <= '0; new_rflags <= '0;
    end else begin
      done <= 1'b0; fault <= 1'b0; unsup <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          l_vec <= vector; l_rip <= cur_rip; l_rsp <= cur_rsp; l_flg <= cur_rflags;
          l_cs <= cur_cs; l_ss <= cur_ss; l_cpl <= cur_cpl;
          step <= '0; st <= S_REQ;
        end
        S_REQ: if (mem_req_ready) begin
          if (!mem_req_write) st <= S_RSP;
          else if (step == 4'(LAST_STEP)) begin
            new_rip    <= {g_hi[31:0], g_lo[63:48], g_lo[15:0]};
            new_cs     <= sel;
            new_ss     <= l_ss;
            new_rsp    <= frame;
            new_rflags <= flg_out;
            done <= 1'b1; st <= S_IDLE;
          end else step <= step + 4'd1;
        end
        S_RSP: if (mem_rsp_valid) begin
          if (step == 4'd0) g_lo <= mem_rsp_rdata;
          if (step == 4'd1) g_hi <= mem_rsp_rdata;
          if (bad) begin
            done <= 1'b1; fault <= 1'b1; st <= S_IDLE;
          end else if (step == 4'd2 && stk_sw) begin
            done <= 1'b1; unsup <= 1'b1; st <= S_IDLE;
          end else begin
            step <= step + 4'd1; st <= S_REQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_FLAG_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (fault || unsup) |-> done && !(fault && unsup)); // R11
  AST_NO_COMMIT_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    done && (fault || unsup) |-> $stable(new_rip) && $stable(new_rsp) && $stable(new_rflags)); // R2
  AST_QUIET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(new_cs) && $stable(new_ss)); // R11
  AST_RSP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault && !unsup |-> new_rsp[3:0] == 4'h0); // R10
  AST_FLAGS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault && !unsup |-> !new_rflags[8] && !new_rflags[14] && !new_rflags[16]); // R9

endmodule

// File: tb/tb_lm_irq_dispatch.sv
module tb_lm_irq_dispatch;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] vector = '0;
  logic [63:0] cur_rip = '0, cur_rsp = '0, cur_rflags = '0;
  logic [15:0] cur_cs = '0, cur_ss = '0;
  logic [1:0] cur_cpl = '0;
  logic [63:0] idt_base = 64'h0, gdt_base = 64'h1000, ldt_base = 64'h2000;
  logic mem_req_valid, mem_req_write, mem_req_ready;
  logic [63:0] mem_req_addr, mem_req_wdata;
  logic mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [63:0] mem_rsp_rdata = '0;
  logic busy, done, fault, unsup;
  logic [63:0] new_rip, new_rsp, new_rflags;
  logic [15:0] new_cs, new_ss;

  always #2 clk = ~clk;

  lm_irq_dispatch dut (.*);

  logic [63:0] idt_m [0:31];
  logic [63:0] gdt_m [0:31];
  logic [63:0] ldt_m [0:31];
  logic [63:0] stk_m [0:511];
  logic [63:0] err_addr = 64'hFFFF_FFFF_FFFF_FFFF;
  logic [63:0] rd_log [0:255];
  logic [63:0] wa_log [0:255];
  logic [63:0] wd_log [0:255];
  int rd_n = 0, wr_n = 0, done_n = 0;
  logic [7:0] rdy_cnt = '0;
  int checks = 0, fails = 0;

  assign mem_req_ready = (rdy_cnt[1:0] != 2'b01);

  function automatic logic [63:0] rd_word(input logic [63:0] a);
    case (a[15:12])
      4'h0: rd_word = idt_m[a[7:3]];
      4'h1: rd_word = gdt_m[a[7:3]];
      4'h2: rd_word = ldt_m[a[7:3]];
      4'h8: rd_word = stk_m[a[11:3]];
      default: rd_word = '0;
    endcase
  endfunction

  always @(posedge clk) begin
    rdy_cnt <= rdy_cnt + 8'd1;
    mem_rsp_valid <= 1'b0;
    if (done) done_n <= done_n + 1;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        stk_m[mem_req_addr[11:3]] <= mem_req_wdata;
        wa_log[wr_n[7:0]] <= mem_req_addr;
        wd_log[wr_n[7:0]] <= mem_req_wdata;
        wr_n <= wr_n + 1;
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= rd_word(mem_req_addr);
        mem_rsp_err <= (mem_req_addr == err_addr);
        rd_log[rd_n[7:0]] <= mem_req_addr;
        rd_n <= rd_n + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] gate_lo(input logic [63:0] off, input logic [15:0] s,
                                          input logic [7:0] ty, input logic [2:0] ist);
    gate_lo = {off[31:16], ty, 5'b0, ist, s, off[15:0]};
  endfunction

  int r0, w0, d0;

  task automatic run(input logic [7:0] v);
    @(negedge clk);
    r0 = rd_n; w0 = wr_n; d0 = done_n;
    vector = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 500; i++) begin
      if (done) break;
      @(negedge clk);
    end
    chk("R11 done seen", {63'b0, done}, 64'd1);
  endtask

  task automatic set_ctx(input logic [63:0] rip, input logic [63:0] rsp, input logic [63:0] fl,
                         input logic [1:0] cpl);
    cur_rip = rip; cur_rsp = rsp; cur_rflags = fl; cur_cpl = cpl;
    cur_cs = 16'h0033; cur_ss = 16'h002B;
  endtask

  task automatic t_reset;
    chk("R11 reset done", {63'b0, done}, 64'd0);
    chk("R12 reset busy", {63'b0, busy}, 64'd0);
    chk("R12 reset req", {63'b0, mem_req_valid}, 64'd0);
    chk("R8 reset rip", new_rip, 64'd0);
  endtask

  task automatic t_int_gate;
    idt_m[6] = gate_lo(64'h0000_00AB_1234_5678, 16'h0010, 8'h8E, 3'd0);
    idt_m[7] = 64'h0000_0000_0000_00AB;
    gdt_m[2] = 64'h0020_9A00_0000_0000;
    set_ctx(64'h0000_7FFF_0000_1000, 64'h8F3C, 64'h0001_4302, 2'd0);
    run(8'd3);
    chk("R11 no fault", {62'b0, fault, unsup}, 64'd0);
    chk("R1 gate lo addr", rd_log[r0[7:0]], 64'h30);
    chk("R1 gate hi addr", rd_log[r0[7:0]+8'd1], 64'h38);
    chk("R3 gdt addr", rd_log[r0[7:0]+8'd2], 64'h1010);
    chk("R6 probe low", rd_log[r0[7:0]+8'd3], 64'h8F10);
    chk("R6 probe high", rd_log[r0[7:0]+8'd4], 64'h8F30);
    chk("R6 read count", 64'(rd_n - r0), 64'd5);
    chk("R7 write count", 64'(wr_n - w0), 64'd5);
    for (int k = 0; k < 5; k++)
      chk("R7 write addr", wa_log[w0[7:0]+8'(k)], 64'h8F10 + 64'(8*k));
    chk("R7 rip", wd_log[w0[7:0]], 64'h0000_7FFF_0000_1000);
    chk("R7 cs", wd_log[w0[7:0]+8'd1], 64'h33);
    chk("R7 flags", wd_log[w0[7:0]+8'd2], 64'h0001_4302);
    chk("R7 rsp", wd_log[w0[7:0]+8'd3], 64'h8F3C);
    chk("R7 ss", wd_log[w0[7:0]+8'd4], 64'h2B);
    chk("R8 new rip", new_rip, 64'h0000_00AB_1234_5678);
    chk("R9 int gate flags", new_rflags, 64'h2);
    chk("R10 new cs", {48'b0, new_cs}, 64'h10);
    chk("R10 new ss", {48'b0, new_ss}, 64'h2B);
    chk("R10 new rsp", new_rsp, 64'h8F10);
  endtask

  task automatic t_trap_gate;
    idt_m[4] = gate_lo(64'hFFFF_8000_DEAD_BEEF, 16'h001C, 8'h8F, 3'd0);
    idt_m[5] = 64'h0000_0000_FFFF_8000;
    ldt_m[3] = 64'h0020_FA00_0000_0000;
    set_ctx(64'h4000, 64'h8E08, 64'h100, 2'd3);
    run(8'd2);
    chk("R11 trap ok", {62'b0, fault, unsup}, 64'd0);
    chk("R3 ldt addr", rd_log[r0[7:0]+8'd2], 64'h2018);
    chk("R8 trap rip", new_rip, 64'hFFFF_8000_DEAD_BEEF);
    chk("R9 trap flags", new_rflags, 64'h200);
    chk("R10 trap cs", {48'b0, new_cs}, 64'h1C);
    chk("R10 trap rsp", new_rsp, 64'h8DE0);
    chk("R7 trap flags pushed", wd_log[w0[7:0]+8'd2], 64'h100);
  endtask

  task automatic t_gate_bad(input logic [7:0] ty, input string tag);
    logic [63:0] prev;
    prev = new_rip;
    idt_m[12] = gate_lo(64'h1111_2222, 16'h0010, ty, 3'd0);
    idt_m[13] = 64'h0;
    set_ctx(64'h5000, 64'h8F3C, 64'h202, 2'd0);
    run(8'd6);
    chk({"R2 fault ", tag}, {62'b0, fault, unsup}, 64'd2);
    chk({"R2 reads ", tag}, 64'(rd_n - r0), 64'd1);
    chk({"R2 writes ", tag}, 64'(wr_n - w0), 64'd0);
    chk({"R2 rip held ", tag}, new_rip, prev);
  endtask

  task automatic t_ist;
    logic [63:0] prev;
    prev = new_rsp;
    idt_m[8] = gate_lo(64'h7777, 16'h0010, 8'h8E, 3'd1);
    idt_m[9] = 64'h0;
    set_ctx(64'h5000, 64'h8F3C, 64'h202, 2'd0);
    run(8'd4);
    chk("R4 unsup", {62'b0, fault, unsup}, 64'd1);
    chk("R4 reads", 64'(rd_n - r0), 64'd3);
    chk("R4 writes", 64'(wr_n - w0), 64'd0);
    chk("R4 rsp held", new_rsp, prev);
  endtask

  task automatic t_dpl;
    logic [63:0] prev;
    prev = new_rip;
    idt_m[10] = gate_lo(64'h8888, 16'h0010, 8'h8E, 3'd0);
    idt_m[11] = 64'h0;
    set_ctx(64'h5000, 64'h8F3C, 64'h202, 2'd3);
    run(8'd5);
    chk("R5 unsup", {62'b0, fault, unsup}, 64'd1);
    chk("R5 writes", 64'(wr_n - w0), 64'd0);
    chk("R5 rip held", new_rip, prev);
  endtask

  task automatic t_probe_err;
    logic [63:0] prev;
    prev = new_rip;
    err_addr = 64'h8F30;
    set_ctx(64'h9000, 64'h8F3C, 64'h202, 2'd0);
    run(8'd3);
    err_addr = 64'hFFFF_FFFF_FFFF_FFFF;
    chk("R6 fault", {62'b0, fault, unsup}, 64'd2);
    chk("R6 reads", 64'(rd_n - r0), 64'd5);
    chk("R6 writes", 64'(wr_n - w0), 64'd0);
    chk("R6 rip held", new_rip, prev);
  endtask

  task automatic t_busy_start;
    set_ctx(64'hABCD, 64'h8F3C, 64'h0001_4302, 2'd0);
    @(negedge clk);
    r0 = rd_n; w0 = wr_n; d0 = done_n;
    vector = 8'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    vector = 8'd6; cur_rip = 64'h1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 500; i++) begin
      if (done) break;
      @(negedge clk);
    end
    chk("R12 result ok", {62'b0, fault, unsup}, 64'd0);
    chk("R12 latched rip pushed", wd_log[w0[7:0]], 64'hABCD);
    chk("R12 gate of first vector", new_rip, 64'h0000_00AB_1234_5678);
    repeat (20) @(negedge clk);
    chk("R12 single done", 64'(done_n - d0), 64'd1);
    chk("R12 idle after", {63'b0, busy}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin idt_m[i] = '0; gdt_m[i] = '0; ldt_m[i] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_int_gate();
    t_trap_gate();
    t_gate_bad(8'h8C, "type");
    t_gate_bad(8'h0E, "present");
    t_ist();
    t_dpl();
    t_probe_err();
    t_busy_start();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule